// File: doc/BRIEF.md
# Doze Clock-Ratio Controller

This block keeps a 16-bit clock-divider control word that a bus can write and read back. It uses that word to throttle the CPU without touching the peripheral clock. Everything runs on a single clock. Instead of deriving a slower clock, the block raises a one-cycle CPU enable strobe once every 2^k peripheral cycles. The exponent k is a 3-bit ratio code held in the word. The code takes effect only while the doze-enable bit is set. When that bit is clear, the strobe is high on every cycle.

The word also has a recover-on-interrupt bit. When it is set and an interrupt request is seen, hardware clears the doze-enable bit. The CPU then returns to full rate without any software write. The word also holds a system postscaler select, a clock-source select and a PLL-force bit. These fields are stored and exported as outputs only: the postscaler as a decoded divide ratio, and the source select with a flag for its reserved codes.

Top module: `doze_ratio_ctrl`

## Requirements
- R1: A write stores bits 15:5 of the written word, and the read port shows them in the same positions on the next cycle. The field positions are: recover-on-interrupt at 15, ratio code at 14:12, doze enable at 11, source select at 10:8, postscaler select at 7:6, PLL force at 5.
- R2: Read bits 4:0 are always 0. Written values in those bits are ignored.
- R3: After reset the word reads 16'h3000: ratio code 3, all other bits 0, effective code 0, strobe high.
- R4: While doze enable is 0, the effective ratio code output is 0 whatever the ratio code holds, and the strobe is high every cycle once settled.
- R5: While doze enable is 1 with a steady ratio code c, the strobe is high on exactly one cycle in every 2^c cycles (c=0 means every cycle, c=7 means 1 in 128).
- R6: If recover-on-interrupt is 1 in a cycle where the interrupt request is high, the doze enable reads 0 from the next cycle on.
- R7: If recover-on-interrupt is 0, the interrupt request has no effect on the doze enable.
- R8: If a bus write sets doze enable in the same cycle as a recovery clear, the clear wins. The write's other fields are still stored.
- R9: When the effective code changes, the strobe is high on the cycle after the change first shows at the effective code output, then every 2^code cycles.
- R10: The postscaler divide output is 1, 2, 4 or 8 for select codes 0, 1, 2 and 3.
- R11: The source select and PLL force bits appear on their outputs. The reserved flag is high exactly when the source select is 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe for the control word |
| wr_data | input | 16 | Bus write data |
| irq_req | input | 1 | Level interrupt request |
| rd_data | output | 16 | Current control word |
| cpu_en | output | 1 | CPU clock-enable strobe |
| eff_code | output | 3 | Ratio code in force (0 when doze is off) |
| post_div | output | 4 | Postscaler divide ratio |
| src_sel | output | 3 | Clock-source select field |
| src_reserved | output | 1 | Source select holds a reserved code |
| pll_force | output | 1 | PLL force bit |

## Verification
The bench targets several corner cases, each tied to a distinct design fault:
- A write that raises doze enable while a recovery clear fires in the same cycle. A design with the wrong priority would leave the CPU dozing.
- Interrupt requests with recovery disarmed. A design that clears the enable unconditionally would drop out of doze.
- Ratio changes in the middle of a period. A counter that does not reload would give a late first strobe or a stretched gap.
- Writes of all ones to the low bits, extreme ratio codes 0 and 7, and the reserved source codes.

// File: rtl/dzc_pkg.sv
package dzc_pkg;

    localparam int REG_W  = 16;
    localparam int CODE_W = 3;
    localparam int SRC_W  = 3;
    localparam int POST_W = 2;
    localparam int PAD_W  = 5;
    localparam int DIV_W  = 1 << POST_W;

    typedef struct packed {
        logic              roi;
        logic [CODE_W-1:0] ratio;
        logic              dz_en;
        logic [SRC_W-1:0]  src;
        logic [POST_W-1:0] post;
        logic              pll_on;
    } dz_cfg_t;

    localparam dz_cfg_t CFG_RST = '{
        roi:    1'b0,
        ratio:  CODE_W'(3),
        dz_en:  1'b0,
        src:    '0,
        post:   '0,
        pll_on: 1'b0
    };

    function automatic logic [REG_W-1:0] cfg_pack(input dz_cfg_t c);
        return {c, {PAD_W{1'b0}}};
    endfunction

    function automatic dz_cfg_t cfg_unpack(input logic [REG_W-1:0] w);
        return dz_cfg_t'(w[REG_W-1:PAD_W]);
    endfunction

    function automatic logic [DIV_W-1:0] post_ratio(input logic [POST_W-1:0] s);
        return DIV_W'(1) << s;
    endfunction

    function automatic logic src_is_reserved(input logic [SRC_W-1:0] s);
        return s[SRC_W-1] & s[SRC_W-2];
    endfunction

endpackage

// File: rtl/dzc_cfg_reg.sv
module dzc_cfg_reg
    import dzc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             irq_req,
    output dz_cfg_t          cfg
);

    dz_cfg_t cfg_nxt;
    logic    recover;

    always_comb begin
        recover = cfg.roi & irq_req;
        cfg_nxt = cfg;
        if (wr_en) begin
            cfg_nxt = cfg_unpack(wr_data);
        end
        // hardware recovery overrides any bus value for the enable
        if (recover) begin
            cfg_nxt.dz_en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RST;
        end else begin
            cfg <= cfg_nxt;
        end
    end

endmodule

// File: rtl/dzc_strobe.sv
module dzc_strobe #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] eff_code,
    output logic              cpu_en
);

    localparam int CNT_W = (1 << CODE_W) - 1;

    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] last_code;
    logic [CNT_W:0]    span;
    logic [CNT_W-1:0]  reload;
    logic              changed;

    always_comb begin
        span    = (CNT_W + 1)'(1) << eff_code;
        reload  = CNT_W'(span - (CNT_W + 1)'(1));
        changed = (eff_code != last_code);
        cpu_en  = (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            last_code <= '0;
        end else begin
            last_code <= eff_code;
            if (changed) begin
                cnt <= '0;
            end else if (cnt == '0) begin
                cnt <= reload;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/doze_ratio_ctrl.sv
module doze_ratio_ctrl
    import dzc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              irq_req,
    output logic [REG_W-1:0]  rd_data,
    output logic              cpu_en,
    output logic [CODE_W-1:0] eff_code,
    output logic [DIV_W-1:0]  post_div,
    output logic [SRC_W-1:0]  src_sel,
    output logic              src_reserved,
    output logic              pll_force
);

    dz_cfg_t cfg;

    dzc_cfg_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .irq_req (irq_req),
        .cfg     (cfg)
    );

    always_comb begin
        rd_data      = cfg_pack(cfg);
        eff_code     = cfg.dz_en ? cfg.ratio : '0;
        post_div     = post_ratio(cfg.post);
        src_sel      = cfg.src;
        src_reserved = src_is_reserved(cfg.src);
        pll_force    = cfg.pll_on;
    end

    dzc_strobe #(.CODE_W(CODE_W)) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .eff_code (eff_code),
        .cpu_en   (cpu_en)
    );

endmodule

// File: rtl/dzc_checker.sv
module dzc_checker
    import dzc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              irq_req,
    input logic [REG_W-1:0]  rd_data,
    input logic              cpu_en,
    input logic [CODE_W-1:0] eff_code
);

    p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[PAD_W-1:0] == '0);

    p_unity_when_off_r4: assert property (@(posedge clk) disable iff (rst)
        !rd_data[11] |-> eff_code == '0);

    p_strobe_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && eff_code != '0 && $stable(eff_code)) |=> !cpu_en);

    p_recover_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_data[15] && irq_req) |=> !rd_data[11]);

    p_irq_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[15] && irq_req && !wr_en) |=> $stable(rd_data[11]));

endmodule

bind doze_ratio_ctrl dzc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .irq_req  (irq_req),
    .rd_data  (rd_data),
    .cpu_en   (cpu_en),
    .eff_code (eff_code)
);

// File: tb/doze_ratio_ctrl_test.sv
`timescale 1ns/1ps
module doze_ratio_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        irq_req = 1'b0;
    logic [15:0] rd_data;
    logic        cpu_en;
    logic [2:0]  eff_code;
    logic [3:0]  post_div;
    logic [2:0]  src_sel;
    logic        src_reserved;
    logic        pll_force;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    doze_ratio_ctrl uut (.*);

    // behavioural reference
    int m_word = 16'h3000;
    int m_wait = 0;
    int m_prev_ratio = 0;

    function automatic int m_ratio();
        return ((m_word >> 11) & 1) != 0 ? ((m_word >> 12) & 7) : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_word = 16'h3000;
            m_wait = 0;
            m_prev_ratio = 0;
        end else begin
            int r;
            int nw;
            r = m_ratio();
            if (r != m_prev_ratio) m_wait = 0;
            else if (m_wait == 0) m_wait = (1 << r) - 1;
            else m_wait = m_wait - 1;
            m_prev_ratio = r;
            nw = wr_en ? (int'(wr_data) & 16'hFFE0) : m_word;
            if (((m_word >> 15) & 1) != 0 && irq_req) nw = nw & ~(1 << 11);
            m_word = nw;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R1 rd_data", int'(rd_data), m_word);
            check("R4 eff_code", int'(eff_code), m_ratio());
            check("R5 cpu_en", int'(cpu_en), m_wait == 0 ? 1 : 0);
            check("R10 post_div", int'(post_div), 1 << ((m_word >> 6) & 3));
            check("R11 src_sel", int'(src_sel), (m_word >> 8) & 7);
            check("R11 src_reserved", int'(src_reserved), ((m_word >> 8) & 7) >= 6 ? 1 : 0);
            check("R11 pll_force", int'(pll_force), (m_word >> 5) & 1);
        end
    end

    task automatic step(input bit w, input logic [15:0] d, input bit irq);
        @(negedge clk);
        wr_en = w;
        wr_data = d;
        irq_req = irq;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int strobes;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3: reset value
        check("R3 reset word", int'(rd_data), 16'h3000);
        check("R3 reset strobe", int'(cpu_en), 1);
        check("R3 reset eff", int'(eff_code), 0);

        // R2: low bits discarded
        step(1, 16'hFFFF, 0);
        step(0, '0, 0);
        check("R2 low bits", int'(rd_data), 16'hFFE0);
        check("R11 reserved code 7", int'(src_reserved), 1);

        // R4: ratio code set but doze off -> every cycle
        step(1, 16'h7000, 0);
        idle(3);
        strobes = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            strobes += int'(cpu_en);
        end
        check("R4 strobes while off", strobes, 8);

        // R5 and R9: enable at 1:4, count strobes over 16 cycles
        step(1, 16'h2800, 0);
        step(0, '0, 0);
        step(0, '0, 0);
        check("R9 first strobe after change", int'(cpu_en), 1);
        strobes = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            strobes += int'(cpu_en);
        end
        check("R5 1:4 strobe count", strobes, 4);

        // R5: 1:128 extreme
        step(1, 16'h7800, 0);
        idle(2);
        strobes = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            strobes += int'(cpu_en);
        end
        check("R5 1:128 strobe count", strobes, 2);

        // R7: recovery disarmed, irq ignored
        step(1, 16'h3800, 0);
        step(0, '0, 1);
        idle(2);
        check("R7 enable kept", int'(rd_data[11]), 1);

        // R6: arm recovery, then irq
        step(1, 16'hB800, 0);
        idle(5);
        step(0, '0, 1);
        step(0, '0, 0);
        check("R6 enable cleared", int'(rd_data[11]), 0);
        check("R6 ratio back to unity", int'(eff_code), 0);

        // R8: write enable with coincident recovery clear
        step(1, 16'hB800, 0);
        step(1, 16'hD8C0, 1);
        step(0, '0, 0);
        check("R8 clear beats write", int'(rd_data), 16'hD0C0);

        // R10 and R11: walk postscaler and source codes
        for (int p = 0; p < 4; p++) begin
            step(1, 16'((p << 6) | (((p + 4) & 7) << 8) | 16'h0020), 0);
            step(0, '0, 0);
            check("R10 post_div", int'(post_div), 1 << p);
        end

        // mixed pseudo-random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom;
            step((r & 15) == 0, 16'(r >> 8), ((r >> 4) & 7) == 0);
        end
        idle(4);
        finish_run();
    end

endmodule